// File: doc/BRIEF.md
# CAN transmit mailbox priority selector

This block picks the next transmit mailbox to hand to the CAN bit engine. Each of the mailboxes 1 to NUM_MB can raise a pending request. Each mailbox also carries an 11-bit base identifier, an 18-bit identifier extension, a frame-format flag and a remote-request flag. On every clock the block looks at all pending mailboxes and registers a winner. The output is a valid flag and the number of the mailbox to send.

Two orderings are available. In identifier order, the pending mailboxes contend exactly as nodes that start transmitting together would contend on a wired-AND bus, so the lowest arbitration field wins. In number order, the highest pending mailbox number wins. The ordering is held in a one-bit mode register. Software may change this register only while the controller is in its configuration state (reset or halt). A write made at any other time is dropped.

Top module: `can_tx_prio_sel`

## Requirements
- R1: After reset, `sel_valid_o` is 0, `sel_idx_o` is 0 and the ordering is identifier order (mode 0).
- R2: In identifier order (mode 0), the pending mailbox with the numerically lowest arbitration field wins. Mailbox m is bit m-1 of `pend_i`, and its fields sit at slice (m-1) of each packed identifier port.
- R3: The arbitration field is compared from its most significant part down: base identifier (MSB first), then the format flag, then the 18-bit extension only when the format flag is 1, then the remote flag. A data frame (remote flag 0) therefore beats a remote frame whose other fields are equal. For two extended frames, the extension is compared before the remote flag.
- R4: For a frame with format flag 0, the extension bits have no effect. Such a frame beats any extended frame that has the same base identifier.
- R5: If two pending mailboxes have equal arbitration fields, the higher mailbox number wins.
- R6: In number order (mode 1), the highest-numbered pending mailbox wins, whatever its identifiers.
- R7: `mode_wdata_i` is loaded into the mode register at a clock edge only when both `mode_we_i` and `cfg_open_i` are 1. Otherwise the write is ignored.
- R8: When no mailbox is pending, `sel_valid_o` is 0 and `sel_idx_o` is 0.
- R9: The selection is registered. The output after edge e reflects `pend_i` and the identifiers sampled at edge e, using the mode held before edge e. A mode write accepted at edge e therefore first shows in the output after edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_MB | Pending request; bit m-1 is mailbox m |
| std_id_i | input | NUM_MB*11 | Base identifiers, mailbox m at bits (m-1)*11 upward |
| ide_i | input | NUM_MB | Format flag per mailbox, 1 = extended |
| ext_id_i | input | NUM_MB*18 | Identifier extensions, mailbox m at bits (m-1)*18 upward |
| rtr_i | input | NUM_MB | Remote-request flag per mailbox |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 1 | Mode value: 0 identifier order, 1 number order |
| cfg_open_i | input | 1 | High while the controller is in reset or halt state |
| sel_valid_o | output | 1 | A mailbox is selected |
| sel_idx_o | output | $clog2(NUM_MB+1) | Selected mailbox number, 0 when none |

## Verification
The bench builds the block with its default of 15 mailboxes. It therefore reaches both end mailboxes, 1 and 15, and the full 4-bit index range.

Directed cases cover the following: a data frame against a remote frame, an extended frame against a standard frame on the same base identifier, standard frames that differ only in ignored extension bits, and exact ties. They also cover a locked mode write followed by an accepted one, with the one-cycle lag. A random phase then draws identifiers from a narrow range so that ties and shared base identifiers are frequent. In that phase a behavioural model, built on integer arithmetic, is compared on every clock.

// File: rtl/can_prio_pkg.sv
package can_prio_pkg;
  localparam int STD_W = 11;
  localparam int EXT_W = 18;
  localparam int KEY_W = STD_W + 1 + EXT_W + 1;

  // Arbitration key: lower value wins. Standard frames place RTR right after
  // the format flag and zero-fill, so extension bits never take part.
  function automatic logic [KEY_W-1:0] arb_key(
    input logic [STD_W-1:0] std_id,
    input logic             ide,
    input logic [EXT_W-1:0] ext_id,
    input logic             rtr
  );
    logic [EXT_W:0] tail;
    tail = ide ? {ext_id, rtr} : {rtr, {EXT_W{1'b0}}};
    return {std_id, ide, tail};
  endfunction
endpackage

// File: rtl/can_arb_key.sv
module can_arb_key
  import can_prio_pkg::*;
#(
  parameter int NUM_MB = 15
) (
  input  logic                          id_mode_i,
  input  logic [NUM_MB*STD_W-1:0]       std_id_i,
  input  logic [NUM_MB-1:0]             ide_i,
  input  logic [NUM_MB*EXT_W-1:0]       ext_id_i,
  input  logic [NUM_MB-1:0]             rtr_i,
  output logic [NUM_MB-1:0][KEY_W-1:0]  keys_o
);
  // In number order every key is zero, so the tie rule alone decides.
  for (genvar k = 0; k < NUM_MB; k++) begin : g_key
    assign keys_o[k] = id_mode_i
      ? arb_key(std_id_i[k*STD_W +: STD_W], ide_i[k],
                ext_id_i[k*EXT_W +: EXT_W], rtr_i[k])
      : '0;
  end
endmodule

// File: rtl/can_prio_reduce.sv
module can_prio_reduce #(
  parameter int NUM_MB = 15,
  parameter int KEY_W  = 31,
  parameter int IDX_W  = $clog2(NUM_MB + 1)
) (
  input  logic [NUM_MB-1:0]             pend_i,
  input  logic [NUM_MB-1:0][KEY_W-1:0]  keys_i,
  output logic                          win_valid_o,
  output logic [IDX_W-1:0]              win_idx_o
);
  logic [KEY_W-1:0] best;

  // Ascending scan with <= lets a later (higher) mailbox take an equal key.
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best        = '0;
    for (int k = 0; k < NUM_MB; k++) begin
      if (pend_i[k] && (!win_valid_o || keys_i[k] <= best)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(k + 1);
        best        = keys_i[k];
      end
    end
  end
endmodule

// File: rtl/can_tx_prio_sel.sv
module can_tx_prio_sel
  import can_prio_pkg::*;
#(
  parameter int NUM_MB = 15,
  localparam int IDX_W = $clog2(NUM_MB + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_MB-1:0]       pend_i,
  input  logic [NUM_MB*STD_W-1:0] std_id_i,
  input  logic [NUM_MB-1:0]       ide_i,
  input  logic [NUM_MB*EXT_W-1:0] ext_id_i,
  input  logic [NUM_MB-1:0]       rtr_i,
  input  logic                    mode_we_i,
  input  logic                    mode_wdata_i,
  input  logic                    cfg_open_i,
  output logic                    sel_valid_o,
  output logic [IDX_W-1:0]        sel_idx_o
);
  logic                          num_mode_q;
  logic                          id_mode;
  logic                          mode_take;
  logic [NUM_MB-1:0][KEY_W-1:0]  keys;
  logic                          win_valid;
  logic [IDX_W-1:0]              win_idx;

  assign id_mode   = ~num_mode_q;
  assign mode_take = mode_we_i & cfg_open_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         num_mode_q <= 1'b0;
    else if (mode_take) num_mode_q <= mode_wdata_i;
  end

  can_arb_key #(.NUM_MB(NUM_MB)) u_key (
    .id_mode_i (id_mode),
    .std_id_i  (std_id_i),
    .ide_i     (ide_i),
    .ext_id_i  (ext_id_i),
    .rtr_i     (rtr_i),
    .keys_o    (keys)
  );

  can_prio_reduce #(.NUM_MB(NUM_MB), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_red (
    .pend_i      (pend_i),
    .keys_i      (keys),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid_o <= 1'b0;
      sel_idx_o   <= '0;
    end else begin
      sel_valid_o <= win_valid;
      sel_idx_o   <= win_idx;
    end
  end

  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> pend_i[win_idx - IDX_W'(1)]); // R2
  AST_NUM_ORDER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (num_mode_q && win_valid) |-> ((pend_i >> win_idx) == '0)); // R6
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_take |=> $stable(num_mode_q)); // R7
  AST_NONE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !win_valid); // R8
  AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_o |-> (sel_idx_o == '0)); // R8
  AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> (sel_valid_o && sel_idx_o == $past(win_idx))); // R9
  AST_REG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> !sel_valid_o); // R9
endmodule

// File: tb/tb_can_tx_prio_sel.sv
`timescale 1ns/1ps
module tb_can_tx_prio_sel;
  localparam int N = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pend = '0, ide = '0, rtr = '0;
  logic [10:0] sid [N];
  logic [17:0] eid [N];
  logic [N*11-1:0] sid_flat;
  logic [N*18-1:0] eid_flat;
  logic we = 1'b0, wdata = 1'b0, open = 1'b0;
  logic sel_valid;
  logic [3:0] sel_idx;

  int total = 0, bad = 0;
  bit done = 0;

  bit m_mode = 0, m_valid = 0;
  int m_idx = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int k = 0; k < N; k++) begin
      sid_flat[k*11 +: 11] = sid[k];
      eid_flat[k*18 +: 18] = eid[k];
    end

  can_tx_prio_sel #(.NUM_MB(N)) dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .std_id_i(sid_flat),
    .ide_i(ide), .ext_id_i(eid_flat), .rtr_i(rtr), .mode_we_i(we),
    .mode_wdata_i(wdata), .cfg_open_i(open),
    .sel_valid_o(sel_valid), .sel_idx_o(sel_idx)
  );

  // Weight of the arbitration field, computed arithmetically.
  function automatic longint weight(int m);
    longint w;
    w = longint'(sid[m-1]) * (longint'(1) << 20) + longint'(ide[m-1]) * (longint'(1) << 19);
    if (ide[m-1]) w += longint'(eid[m-1]) * 2 + longint'(rtr[m-1]);
    else          w += longint'(rtr[m-1]) * (longint'(1) << 18);
    return w;
  endfunction

  // Winner by scanning from the top mailbox; strict < keeps higher on ties.
  function automatic int ref_pick(bit num_mode);
    int win = 0;
    longint best = 0;
    for (int m = N; m >= 1; m--) begin
      if (pend[m-1]) begin
        if (num_mode) return m;
        if (win == 0 || weight(m) < best) begin
          win = m;
          best = weight(m);
        end
      end
    end
    return win;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_valid <= 0; m_idx <= 0;
    end else begin
      m_idx   <= ref_pick(m_mode);
      m_valid <= (ref_pick(m_mode) != 0);
      if (we && open) m_mode <= wdata;
    end
  end

  always @(negedge clk) if (model_on) begin
    total++;
    if (sel_valid !== m_valid || int'(sel_idx) != m_idx) begin
      bad++;
      $display("FAIL R9 model: got v=%0b idx=%0d exp v=%0b idx=%0d",
               sel_valid, sel_idx, m_valid, m_idx);
    end
  end

  task automatic chk(string req, bit ev, int eidx);
    total++;
    if (sel_valid !== ev || int'(sel_idx) != eidx) begin
      bad++;
      $display("FAIL %s: got v=%0b idx=%0d exp v=%0b idx=%0d",
               req, sel_valid, sel_idx, ev, eidx);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_all();
    pend = '0; ide = '0; rtr = '0;
    for (int k = 0; k < N; k++) begin sid[k] = '0; eid[k] = '0; end
  endtask

  task automatic mb(int m, int s, bit i, int e, bit r);
    pend[m-1] = 1'b1; sid[m-1] = 11'(s); ide[m-1] = i; eid[m-1] = 18'(e); rtr[m-1] = r;
  endtask

  task automatic write_mode(bit v, bit op);
    we = 1'b1; wdata = v; open = op;
    step();
    we = 1'b0; open = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_all();
    pend = 15'h7FFF;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 0, 0);
    rst_n = 1'b1;
    pend = '0;
    @(negedge clk);
    chk("R1 after reset", 0, 0);
    model_on = 1;

    step(); chk("R8 none pending", 0, 0);

    clear_all(); mb(3, 'h100, 0, 0, 0); mb(7, 'h050, 0, 0, 0); mb(12, 'h300, 0, 0, 0);
    step(); chk("R2 lowest base id", 1, 7);

    clear_all(); mb(4, 'h123, 0, 0, 1); mb(9, 'h123, 0, 0, 0);
    step(); chk("R3 data beats remote", 1, 9);

    clear_all(); mb(5, 'h123, 1, 5, 0); mb(6, 'h123, 1, 3, 1);
    step(); chk("R3 ext before rtr", 1, 6);

    clear_all(); mb(1, 'h0FF, 1, 0, 0); mb(15, 'h100, 0, 0, 0);
    step(); chk("R3 base id first", 1, 1);

    clear_all(); mb(10, 'h200, 0, 'h3FFFF, 1); mb(2, 'h200, 1, 0, 0);
    step(); chk("R4 standard beats extended", 1, 10);

    clear_all(); mb(8, 'h055, 0, 'h3FFFF, 0); mb(1, 'h055, 0, 0, 0);
    step(); chk("R4 ext bits ignored", 1, 8);

    clear_all(); mb(5, 'h07A, 1, 'h1234, 1); mb(11, 'h07A, 1, 'h1234, 1);
    step(); chk("R5 tie to higher", 1, 11);

    clear_all(); mb(3, 'h001, 0, 0, 0); mb(14, 'h7FF, 1, 'h3FFFF, 1);
    step(); chk("R2 setup", 1, 3);
    write_mode(1, 0);
    step(); chk("R7 locked write ignored", 1, 3);
    write_mode(1, 1);
    chk("R9 mode lag", 1, 3);
    step(); chk("R6 number order", 1, 14);

    clear_all(); mb(1, 0, 0, 0, 0); mb(6, 0, 0, 0, 0);
    step(); chk("R6 highest number", 1, 6);
    write_mode(0, 0);
    step(); chk("R7 locked clear ignored", 1, 6);
    pend = '0;
    step(); chk("R8 drop to idle", 0, 0);
    write_mode(0, 1);

    for (int c = 0; c < 3000; c++) begin
      for (int k = 0; k < N; k++) begin
        pend[k] = ($urandom_range(0, 2) == 0);
        sid[k] = 11'($urandom_range(0, 3));
        ide[k] = 1'($urandom_range(0, 1));
        eid[k] = 18'($urandom_range(0, 3));
        rtr[k] = 1'($urandom_range(0, 1));
      end
      we = ($urandom_range(0, 9) == 0);
      wdata = 1'($urandom_range(0, 1));
      open = 1'($urandom_range(0, 1));
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule